// File: doc/BRIEF.md
# DDR SDRAM Periodic Refresh Scheduler

This block sits beside the main command arbiter of a DDR SDRAM controller and makes sure the memory is refreshed on time. A free-running interval timer adds one owed refresh every `REFI_CYC` clock cycles. While anything is owed, the block raises a bus request toward the arbiter. Once granted, it issues the refresh on the command pins. If the arbiter reports that some bank is still open, it first closes every bank with a precharge-all command. It then keeps the bus for the refresh recovery window so that no other command lands too early.

Refreshes may be postponed. Up to eight can be owed at once, and the count never grows past that cap. When seven are owed, an urgent flag tells the arbiter to stop deferring. An optional self-refresh mode is also included. When the host asks for it, the block drops the clock enable while issuing the refresh encoding. On exit it raises the clock enable and observes two separate recovery windows: a short one for ordinary commands and a long one for reads.

Top module: `refresh_sched`

## Requirements
- R1: One refresh is added to the owed count every `REFI_CYC` cycles while the memory is not in self-refresh. After reset is released, `ref_req` first rises exactly `REFI_CYC` cycles later. The timer restarts from a full period in the first cycle with `ddr_cke` high after self-refresh.
- R2: The owed count never exceeds `OWED_MAX` (8), and ticks arriving at the cap are dropped. Granting the bus after k intervals without service yields exactly min(k, 8) refresh commands before `ref_req` falls.
- R3: `ref_req` is high whenever a refresh is owed, self-refresh is requested, or a sequence is in progress. A grant while nothing is pending leaves the bus at no-operation.
- R4: If `banks_idle` is low when a pending request is granted, the block first issues precharge-all (cs_n=0, ras_n=0, cas_n=1, we_n=0, a10=1). Auto-refresh follows exactly `TRP_CYC` cycles later, without sampling `banks_idle` again.
- R5: Auto-refresh is encoded as cs_n=0, ras_n=0, cas_n=0, we_n=1 with `ddr_cke` high, and each one removes one owed refresh. For the `TRFC_CYC` cycles starting with the refresh, the bus carries no-operation after the refresh and `ref_req` stays high. With the grant held, consecutive refreshes are `TRFC_CYC`+1 cycles apart.
- R6: An interval tick in the same cycle as an issued refresh leaves the owed count unchanged.
- R7: `ref_urgent` is high exactly when the owed count is at least `URGENT_LVL` (7). With no grant, it rises 6×`REFI_CYC` cycles after `ref_req` rises.
- R8: When `sr_req` is high at a grant, self-refresh takes priority over an owed refresh. The block issues the refresh encoding with `ddr_cke` falling in that same cycle and clears the owed count. While `sr_req` stays high, `ddr_cke` stays low, the bus carries no-operation and no refresh is issued.
- R9: `ddr_cke` rises in the cycle after `sr_req` is seen low. `ref_req` stays high for `XSNR_CYC` cycles starting at that cycle, which covers the recovery window for commands other than reads.
- R10: `read_ok` is low from self-refresh entry until `XSRD_CYC` cycles after `ddr_cke` rises, and high otherwise.
- R11: Reset leaves no-operation on the bus (cs_n=0, ras_n=1, cas_n=1, we_n=1, a10=0), `ddr_cke` high, `ref_req` and `ref_urgent` low, `read_ok` high and nothing owed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_gnt | input | 1 | Arbiter grants the bus to this block (sampled while idle) |
| banks_idle | input | 1 | High when every bank is precharged |
| sr_req | input | 1 | Level request to enter and remain in self-refresh |
| ref_req | output | 1 | Bus request; while high after a grant, the block owns the bus |
| ref_urgent | output | 1 | Owed count has reached the urgent level |
| read_ok | output | 1 | Read commands are permitted (self-refresh exit window elapsed) |
| ddr_cke | output | 1 | Clock enable to the memory |
| ddr_cs_n | output | 1 | Chip select, active low |
| ddr_ras_n | output | 1 | Row strobe, active low |
| ddr_cas_n | output | 1 | Column strobe, active low |
| ddr_we_n | output | 1 | Write enable, active low |
| ddr_a10 | output | 1 | Address bit 10; high selects all banks on precharge |

## Verification
A wrong owed count shows up at the ports as the wrong number of refresh commands in a single granted drain, or as `ref_urgent` at the wrong time. Both are visible within one interval of the fault, so the bench sweeps the backlog from one to ten intervals. A wrong timer shifts the rise of `ref_req` away from its period within `REFI_CYC` cycles. A broken hold or exit counter moves the fall of `ref_req` or the rise of `read_ok` by a cycle. The bench therefore samples those edges on both sides.

// File: rtl/refsched_pkg.sv
package refsched_pkg;

    typedef enum logic [2:0] {
        RS_IDLE,
        RS_PRECH,
        RS_RFC,
        RS_SELF,
        RS_XSR
    } rs_state_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
        logic a10;
    } rs_cmd_t;

    localparam rs_cmd_t RS_CMD_NOP  = 5'b01110;
    localparam rs_cmd_t RS_CMD_PALL = 5'b00101;
    localparam rs_cmd_t RS_CMD_AREF = 5'b00010;

    typedef struct packed {
        rs_state_e st;
        rs_cmd_t   cmd;
        logic      cke;
    } rs_ctl_t;

endpackage

// File: rtl/rs_interval_timer.sv
module rs_interval_timer #(
    parameter int unsigned PERIOD = 1040
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int unsigned CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [CW-1:0] RELOAD = CW'(PERIOD - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (!run || cnt_q == '0) cnt_d = RELOAD;
        else                     cnt_d = cnt_q - 1'b1;
    end

    assign tick = run && (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= RELOAD;
        else        cnt_q <= cnt_d;
    end

    // R1: a tick is never followed by another tick in the next cycle
    a_r1_single_tick: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    // R1: a stopped timer restarts from a full period
    a_r1_restart_full: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt_q == RELOAD));
endmodule

// File: rtl/rs_owed_ctr.sv
module rs_owed_ctr #(
    parameter int unsigned OWED_MAX   = 8,
    parameter int unsigned URGENT_LVL = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic take,
    input  logic clear,
    output logic pending,
    output logic urgent
);
    localparam int unsigned OW = $clog2(OWED_MAX + 1);
    localparam logic [OW-1:0] CAP = OW'(OWED_MAX);
    localparam logic [OW-1:0] URG = OW'(URGENT_LVL);

    logic [OW-1:0] owed_d, owed_q;
    logic          dec;

    assign dec = take && (owed_q != '0);

    always_comb begin
        owed_d = owed_q;
        if (clear)                      owed_d = '0;
        else if (tick && !dec)          owed_d = (owed_q == CAP) ? owed_q : owed_q + 1'b1;
        else if (dec && !tick)          owed_d = owed_q - 1'b1;
    end

    assign pending = (owed_q != '0);
    assign urgent  = (owed_q >= URG);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) owed_q <= '0;
        else        owed_q <= owed_d;
    end

    // R2: the backlog stays within the cap
    a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        owed_q <= CAP);

    // R6: simultaneous tick and service keep the backlog
    a_r6_tick_meets_take: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && take && pending && !clear) |=> $stable(owed_q));

    // R8: clearing empties the backlog
    a_r8_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !pending);
endmodule

// File: rtl/rs_hold_ctr.sv
module rs_hold_ctr #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] val,
    output logic         done
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (load)              cnt_d = val;
        else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
        else                   cnt_d = cnt_q;
    end

    assign done = (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R5: an expired window stays expired until reloaded
    a_r5_stays_done: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !load) |=> done);
endmodule

// File: rtl/refresh_sched.sv
module refresh_sched
    import refsched_pkg::*;
#(
    parameter int unsigned REFI_CYC   = 1040,
    parameter int unsigned TRP_CYC    = 3,
    parameter int unsigned TRFC_CYC   = 10,
    parameter int unsigned XSNR_CYC   = 10,
    parameter int unsigned XSRD_CYC   = 200,
    parameter int unsigned OWED_MAX   = 8,
    parameter int unsigned URGENT_LVL = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_gnt,
    input  logic banks_idle,
    input  logic sr_req,
    output logic ref_req,
    output logic ref_urgent,
    output logic read_ok,
    output logic ddr_cke,
    output logic ddr_cs_n,
    output logic ddr_ras_n,
    output logic ddr_cas_n,
    output logic ddr_we_n,
    output logic ddr_a10
);
    localparam int unsigned MAX_A    = (TRP_CYC > TRFC_CYC) ? TRP_CYC : TRFC_CYC;
    localparam int unsigned HOLD_MAX = (MAX_A > XSNR_CYC) ? MAX_A : XSNR_CYC;
    localparam int unsigned HW       = $clog2(HOLD_MAX + 1);
    localparam int unsigned RW       = $clog2(XSRD_CYC + 1);
    localparam logic [HW-1:0] LD_RP   = HW'(TRP_CYC - 1);
    localparam logic [HW-1:0] LD_RFC  = HW'(TRFC_CYC - 1);
    localparam logic [HW-1:0] LD_XSNR = HW'(XSNR_CYC - 1);
    localparam logic [RW-1:0] LD_XSRD = RW'(XSRD_CYC);
    localparam rs_ctl_t CTL_RESET = '{st: RS_IDLE, cmd: RS_CMD_NOP, cke: 1'b1};

    rs_ctl_t       ctl_d, ctl_q;
    logic          tick, owed_pending, pending;
    logic          take, clr, launch;
    logic          hload, hold_done, rload, rd_done;
    logic [HW-1:0] hval;

    rs_interval_timer #(.PERIOD(REFI_CYC)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(ctl_q.st != RS_SELF), .tick(tick)
    );

    rs_owed_ctr #(.OWED_MAX(OWED_MAX), .URGENT_LVL(URGENT_LVL)) u_owed (
        .clk(clk), .rst_n(rst_n), .tick(tick), .take(take), .clear(clr),
        .pending(owed_pending), .urgent(ref_urgent)
    );

    rs_hold_ctr #(.W(HW)) u_hold (
        .clk(clk), .rst_n(rst_n), .load(hload), .val(hval), .done(hold_done)
    );

    rs_hold_ctr #(.W(RW)) u_rdhold (
        .clk(clk), .rst_n(rst_n), .load(rload), .val(LD_XSRD), .done(rd_done)
    );

    assign pending = owed_pending || sr_req;

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.cmd = RS_CMD_NOP;
        take      = 1'b0;
        clr       = 1'b0;
        hload     = 1'b0;
        hval      = '0;
        rload     = 1'b0;
        launch    = 1'b0;
        case (ctl_q.st)
            RS_IDLE: begin
                if (pending && ref_gnt) begin
                    if (!banks_idle) begin
                        ctl_d.cmd = RS_CMD_PALL;
                        ctl_d.st  = RS_PRECH;
                        hload     = 1'b1;
                        hval      = LD_RP;
                    end else begin
                        launch = 1'b1;
                    end
                end
            end
            RS_PRECH: if (hold_done) launch = 1'b1;
            RS_RFC:   if (hold_done) ctl_d.st = RS_IDLE;
            RS_SELF: begin
                if (!sr_req) begin
                    ctl_d.cke = 1'b1;
                    ctl_d.st  = RS_XSR;
                    hload     = 1'b1;
                    hval      = LD_XSNR;
                    rload     = 1'b1;
                end
            end
            RS_XSR:   if (hold_done) ctl_d.st = RS_IDLE;
            default:  ctl_d.st = RS_IDLE;
        endcase
        if (launch) begin
            if (sr_req) begin
                ctl_d.cmd = RS_CMD_AREF;
                ctl_d.cke = 1'b0;
                ctl_d.st  = RS_SELF;
                clr       = 1'b1;
            end else if (owed_pending) begin
                ctl_d.cmd = RS_CMD_AREF;
                ctl_d.st  = RS_RFC;
                take      = 1'b1;
                hload     = 1'b1;
                hval      = LD_RFC;
            end else begin
                ctl_d.st  = RS_IDLE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= CTL_RESET;
        else        ctl_q <= ctl_d;
    end

    assign ref_req   = (ctl_q.st != RS_IDLE) || pending;
    assign read_ok   = rd_done && (ctl_q.st != RS_SELF);
    assign ddr_cke   = ctl_q.cke;
    assign ddr_cs_n  = ctl_q.cmd.cs_n;
    assign ddr_ras_n = ctl_q.cmd.ras_n;
    assign ddr_cas_n = ctl_q.cmd.cas_n;
    assign ddr_we_n  = ctl_q.cmd.we_n;
    assign ddr_a10   = ctl_q.cmd.a10;

    // R4: an open bank at grant time leads to precharge-all first
    a_r4_close_banks_first: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == RS_IDLE && pending && ref_gnt && !banks_idle)
        |=> (ctl_q.cmd == RS_CMD_PALL));

    // R5: an auto-refresh is followed by an idle bus while ownership is kept
    a_r5_refresh_holdoff: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.cmd == RS_CMD_AREF && ctl_q.cke) |=> (ctl_q.cmd == RS_CMD_NOP && ref_req));

    // R7: urgency implies a standing request
    a_r7_urgent_requests: assert property (@(posedge clk) disable iff (!rst_n)
        ref_urgent |-> ref_req);

    // R8: clock enable only falls together with the refresh encoding
    a_r8_entry_encoding: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctl_q.cke) |-> (ctl_q.cmd == RS_CMD_AREF));

    // R10: no read is permitted while the clock enable is low
    a_r10_no_read_in_self: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_q.cke |-> !read_ok);
endmodule

// File: tb/test_refresh_sched.sv
module test_refresh_sched;
    localparam int REFI = 64;
    localparam int TRP  = 3;
    localparam int TRFC = 5;
    localparam int XSNR = 4;
    localparam int XSRD = 12;

    logic clk = 1'b0, rst_n = 1'b0, ref_gnt = 1'b0, banks_idle = 1'b1, sr_req = 1'b0;
    logic ref_req, ref_urgent, read_ok, ddr_cke;
    logic ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n, ddr_a10;

    refresh_sched #(
        .REFI_CYC(REFI), .TRP_CYC(TRP), .TRFC_CYC(TRFC),
        .XSNR_CYC(XSNR), .XSRD_CYC(XSRD), .OWED_MAX(8), .URGENT_LVL(7)
    ) i_refresh_sched (
        .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt), .banks_idle(banks_idle),
        .sr_req(sr_req), .ref_req(ref_req), .ref_urgent(ref_urgent),
        .read_ok(read_ok), .ddr_cke(ddr_cke), .ddr_cs_n(ddr_cs_n),
        .ddr_ras_n(ddr_ras_n), .ddr_cas_n(ddr_cas_n), .ddr_we_n(ddr_we_n),
        .ddr_a10(ddr_a10)
    );

    always #10 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0;
    int fails  = 0;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int is_ref();
        return (!ddr_cs_n && !ddr_ras_n && !ddr_cas_n && ddr_we_n) ? 1 : 0;
    endfunction
    function automatic int is_pre();
        return (!ddr_cs_n && !ddr_ras_n && ddr_cas_n && !ddr_we_n) ? 1 : 0;
    endfunction
    function automatic int is_nop();
        return (!ddr_cs_n && ddr_ras_n && ddr_cas_n && ddr_we_n && !ddr_a10) ? 1 : 0;
    endfunction
    function automatic int mn(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog (all requirements) actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    task automatic wait_req_rise(output int n);
        n = cyc;
        for (int i = 0; i < 4 * REFI; i++) begin
            @(negedge clk);
            if (ref_req) begin
                n = cyc;
                return;
            end
        end
        chk("R1 request never rose", 0, 1);
    endtask

    task automatic drain(output int cnt, output int gap_err, output int other);
        int last;
        last = -1; cnt = 0; gap_err = 0; other = 0;
        ref_gnt = 1'b1;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (is_ref() == 1) begin
                if (last >= 0 && (cyc - last) != TRFC + 1) gap_err++;
                if (!ddr_cke) other++;
                last = cyc;
                cnt++;
            end else if (is_nop() == 0) begin
                other++;
            end
            if (!ref_req) break;
        end
        ref_gnt = 1'b0;
    endtask

    initial begin
        int r, n, u, cnt, gerr, oth, p, x, bad, k_own;
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11 bus no-operation", is_nop(), 1);
        chk("R11 cke high", ddr_cke, 1);
        chk("R11 request low", ref_req, 0);
        chk("R11 urgent low", ref_urgent, 0);
        chk("R11 read_ok high", read_ok, 1);
        rst_n = 1'b1;
        r = cyc;

        // R1: first interval, R7: urgent after six more
        wait_req_rise(n);
        chk("R1 first interval length", n - r, REFI);
        u = n;
        for (int i = 0; i < 8 * REFI; i++) begin
            @(negedge clk);
            if (ref_urgent) begin u = cyc; break; end
        end
        chk("R7 urgent rise delay", u - n, 6 * REFI);
        drain(cnt, gerr, oth);
        chk("R2 drain of seven", cnt, 7);
        chk("R5 refresh spacing", gerr, 0);
        chk("R5 only no-operation between refreshes", oth, 0);

        // R2 / R7 sweep over backlog depth, including saturation
        for (int k = 1; k <= 10; k++) begin
            k_own = mn(k, 8);
            wait_req_rise(n);
            repeat ((k - 1) * REFI + 2) @(negedge clk);
            chk($sformatf("R7 urgent at backlog %0d", k), ref_urgent, (k_own >= 7) ? 1 : 0);
            drain(cnt, gerr, oth);
            chk($sformatf("R2 refreshes after %0d intervals", k), cnt, k_own);
            chk($sformatf("R5 spacing at backlog %0d", k), gerr + oth, 0);
        end

        // R6: tick and refresh in the same cycle
        wait_req_rise(n);
        repeat (REFI - 1) @(negedge clk);
        ref_gnt = 1'b1;
        @(negedge clk);
        ref_gnt = 1'b0;
        chk("R5 refresh issued on grant", is_ref(), 1);
        repeat (TRFC) @(negedge clk);
        chk("R6 backlog kept after coinciding tick", ref_req, 1);
        drain(cnt, gerr, oth);
        chk("R6 one refresh left", cnt, 1);

        // R3: grant with nothing pending
        bad = 0;
        ref_gnt = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (is_nop() == 0 || ref_req) bad++;
        end
        ref_gnt = 1'b0;
        chk("R3 idle grant ignored", bad, 0);

        // R4: open bank forces precharge-all first
        banks_idle = 1'b0;
        wait_req_rise(n);
        ref_gnt = 1'b1;
        p = 0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            if (is_nop() == 0) begin p = cyc; break; end
        end
        ref_gnt = 1'b0;
        chk("R4 precharge-all encoding", is_pre(), 1);
        chk("R4 precharge selects all banks", ddr_a10, 1);
        bad = 0;
        for (int i = 1; i < TRP; i++) begin
            @(negedge clk);
            if (is_nop() == 0) bad++;
        end
        @(negedge clk);
        chk("R4 refresh after precharge time", is_ref() + bad, 1);
        repeat (TRFC - 1) @(negedge clk);
        chk("R5 ownership through recovery", ref_req, 1);
        @(negedge clk);
        chk("R5 ownership released after recovery", ref_req, 0);
        banks_idle = 1'b1;

        // R8: self-refresh entry with backlog, priority over refresh
        wait_req_rise(n);
        repeat (2 * REFI + 2) @(negedge clk);
        sr_req = 1'b1;
        @(negedge clk);
        chk("R3 request with self-refresh asked", ref_req, 1);
        ref_gnt = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            if (!ddr_cke) break;
        end
        ref_gnt = 1'b0;
        chk("R8 cke falls with refresh encoding", is_ref() * (ddr_cke ? 0 : 1), 1);
        chk("R10 read blocked in self-refresh", read_ok, 0);
        bad = 0;
        for (int i = 0; i < 3 * REFI; i++) begin
            @(negedge clk);
            if (ddr_cke || is_nop() == 0 || read_ok) bad++;
        end
        chk("R8 quiet bus while in self-refresh", bad, 0);

        // R9 / R10: exit windows
        sr_req = 1'b0;
        @(negedge clk);
        x = cyc;
        chk("R9 cke rises after request drops", ddr_cke, 1);
        repeat (XSNR - 1) @(negedge clk);
        chk("R9 ownership in last exit cycle", ref_req, 1);
        @(negedge clk);
        chk("R9 ownership released after exit window", ref_req, 0);
        repeat (XSRD - XSNR - 1) @(negedge clk);
        chk("R10 read still blocked one cycle early", read_ok, 0);
        @(negedge clk);
        chk("R10 read allowed at window end", read_ok, 1);
        repeat (REFI - XSRD - 1) @(negedge clk);
        chk("R1 no request before restarted period", ref_req, 0);
        @(negedge clk);
        chk("R1 request at restarted period", cyc - x, REFI);
        chk("R1 request after exit", ref_req, 1);
        drain(cnt, gerr, oth);
        chk("R8 backlog cleared by self-refresh", cnt, 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule